// File: doc/BRIEF.md
# Peripheral Clock Enable and Reset Sequencer

This block owns two per-peripheral control vectors: a clock-stop vector that gates up to `NUM_CLK` peripheral clocks, and a reset-hold vector that keeps peripherals in reset. A single command port accepts one request at a time. The request carries an opcode, a clock index, a reset index and a flag saying whether the reset index is meaningful. Turning a clock on for a peripheral that has a reset line is a timed procedure. The peripheral is first put into reset. After a settling interval its clock is ungated. After a second, longer interval its reset is released. Turning a clock off only gates it.

The command port also offers direct set, clear and read operations on single reset-hold bits. Both wait intervals are counted in system clock cycles, derived from a cycles-per-microsecond parameter, so that a simulation can shrink them. Clocks flagged critical run from reset and cannot be switched off. One bit of the stop vector, selected by a parameter, uses the opposite polarity from the others.

Top module: `periph_clk_rst_ctl`

## Requirements
- R1: After synchronous reset every reset-hold bit reads 1. Every clock is stopped except those set in `CRIT_MASK` (default bits 2 and 6), so `clk_en` equals `CRIT_MASK`.
- R2: In `stop_reg`, a 1 means the clock is stopped for every bit except bit `INV_BIT` (default 14), where a 1 means the clock runs. With defaults, `stop_reg` resets to 32'hFFFFBFBB.
- R3: An enable request (opcode 0) for a stopped clock with `req_rst_vld`=1 behaves as follows. At the accepting edge it sets the reset bit. `PRE_US*CYC_PER_US` cycles later it ungates the clock. A further `POST_US*CYC_PER_US` cycles later it clears the reset bit, and it raises `done` in the cycle that follows that edge.
- R4: An enable request with `req_rst_vld`=0 ungates the clock at the accepting edge, leaves `rst_reg` unchanged, and raises `done` in the next cycle.
- R5: An enable request for a clock that already runs changes neither register and raises `done` in the next cycle.
- R6: A disable request (opcode 1) sets the clock's stop bit to its stopped polarity and never changes `rst_reg`.
- R7: A disable request for a critical clock is ignored, and that clock stays enabled.
- R8: Reset-set (opcode 2) and reset-clear (opcode 3) change only the bit at `req_rst_idx`.
- R9: Reset-read (opcode 4) latches `rst_reg[req_rst_idx]` into `rst_status`, which holds until the next read.
- R10: `busy` is high from the accepting edge until the end of the single cycle in which `done` is high. A request is accepted only while `busy` is low, and a request presented while `busy` is high has no effect.
- R11: `clk_en[i]` is 1 exactly when clock i runs under the polarity rule of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | 0 enable, 1 disable, 2 reset-set, 3 reset-clear, 4 reset-read; others complete with no effect |
| req_clk_idx | input | IDX_W | Clock index |
| req_rst_idx | input | IDX_W | Reset index |
| req_rst_vld | input | 1 | Enable request has an associated reset bit |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rst_status | output | 1 | Result of the last reset-read |
| stop_reg | output | NUM_CLK | Clock-stop vector |
| rst_reg | output | NUM_CLK | Reset-hold vector |
| clk_en | output | NUM_CLK | Per-clock run indication |

## Verification
Enable requests are issued in three flavours: with a reset bit on a stopped clock, without a reset bit, and on a clock that already runs. The timed flavour's two edges are sampled one cycle either side of where they belong, which separates a correct interval from an off-by-one in either wait. Requests on the inverted-polarity bit and on a critical bit separate the polarity rule from the override rule. A disable strobe injected mid-sequence shows that busy requests are dropped rather than queued.

// File: rtl/cgrs_pkg.sv
// Shared types for the peripheral clock/reset sequencer.
// Assumes: opcode encoding is fixed by the command port definition.
package cgrs_pkg;

    typedef enum logic [2:0] {
        OP_CLK_ON   = 3'd0,
        OP_CLK_OFF  = 3'd1,
        OP_RST_SET  = 3'd2,
        OP_RST_CLR  = 3'd3,
        OP_RST_READ = 3'd4
    } cg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cg_state_e;

endpackage

// File: rtl/cg_timer.sv
// Down-counting interval timer.
// Loading value V makes expired rise V cycles after the load edge.
// Assumes: load is only issued when a wait is about to start.
module cg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cg_regs.sv
// Clock-stop and reset-hold vectors with single-bit write ports.
// Per bit, the generate picks the stop polarity (one inverted bit) and
// whether the clock is critical (stop writes are dropped).
// Assumes: at most one clock write and one reset write per cycle.
module cg_regs #(
    parameter int                  NUM_CLK   = 32,
    parameter int                  INV_BIT   = 14,
    parameter logic [NUM_CLK-1:0]  CRIT_MASK = '0,
    localparam int                 IW        = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_wr,
    input  logic               clk_run,
    input  logic [IW-1:0]      clk_widx,
    input  logic               rst_wr,
    input  logic               rst_val,
    input  logic [IW-1:0]      rst_widx,
    output logic [NUM_CLK-1:0] stop_q,
    output logic [NUM_CLK-1:0] rst_q,
    output logic [NUM_CLK-1:0] clk_en
);
    for (genvar i = 0; i < NUM_CLK; i++) begin : g_bit
        localparam bit INV      = (i == INV_BIT);
        localparam bit CRT      = CRIT_MASK[i];
        localparam bit STOP_RST = CRT ? INV : !INV;
        logic stop_b;
        logic rst_b;

        // Update this bit's stop and reset flops from the write ports.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stop_b <= STOP_RST;
                rst_b  <= 1'b1;
            end else begin
                if (clk_wr && clk_widx == IW'(i) && !(CRT && !clk_run))
                    stop_b <= clk_run ? INV : !INV;
                if (rst_wr && rst_widx == IW'(i))
                    rst_b <= rst_val;
            end
        end

        assign stop_q[i] = stop_b;
        assign rst_q[i]  = rst_b;
        assign clk_en[i] = INV ? stop_b : !stop_b;
    end
endmodule

// File: rtl/cg_seq.sv
// Request sequencer: accepts one command while idle, runs the timed
// reset/ungate/release procedure for enables with a reset line, and
// pulses done for one cycle at the end of every command.
// Assumes: cur_en and rst_bit reflect the indices presented on the port.
module cg_seq
    import cgrs_pkg::*;
#(
    parameter int IW       = 5,
    parameter int CW       = 8,
    parameter int PRE_CYC  = 4,
    parameter int POST_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [IW-1:0] req_clk_idx,
    input  logic [IW-1:0] req_rst_idx,
    input  logic          req_rst_vld,
    input  logic          cur_en,
    input  logic          rst_bit,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          clk_wr,
    output logic          clk_run,
    output logic [IW-1:0] clk_widx,
    output logic          rst_wr,
    output logic          rst_val,
    output logic [IW-1:0] rst_widx,
    output logic          busy,
    output logic          done,
    output logic          status_q
);
    localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] POST_LD = CW'(POST_CYC - 1);

    cg_state_e     state, state_nx;
    logic [IW-1:0] c_idx, r_idx;
    logic          accept;

    assign accept = req_valid && (state == ST_IDLE);

    // Decide next state and the register/timer actions of this cycle.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = PRE_LD;
        clk_wr   = 1'b0;
        clk_run  = 1'b0;
        clk_widx = req_clk_idx;
        rst_wr   = 1'b0;
        rst_val  = 1'b0;
        rst_widx = req_rst_idx;
        unique case (state)
            ST_IDLE: if (accept) begin
                state_nx = ST_DONE;
                case (cg_op_e'(req_op))
                    OP_CLK_ON: if (!cur_en) begin
                        if (req_rst_vld) begin
                            rst_wr   = 1'b1;
                            rst_val  = 1'b1;
                            tmr_load = 1'b1;
                            state_nx = ST_PRE;
                        end else begin
                            clk_wr  = 1'b1;
                            clk_run = 1'b1;
                        end
                    end
                    OP_CLK_OFF: clk_wr = 1'b1;
                    OP_RST_SET: begin
                        rst_wr  = 1'b1;
                        rst_val = 1'b1;
                    end
                    OP_RST_CLR: rst_wr = 1'b1;
                    default: ;
                endcase
            end
            ST_PRE: if (tmr_expired) begin
                clk_wr   = 1'b1;
                clk_run  = 1'b1;
                clk_widx = c_idx;
                tmr_load = 1'b1;
                tmr_val  = POST_LD;
                state_nx = ST_POST;
            end
            ST_POST: if (tmr_expired) begin
                rst_wr   = 1'b1;
                rst_widx = r_idx;
                state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // State register plus the indices held for the timed procedure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            c_idx <= '0;
            r_idx <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                c_idx <= req_clk_idx;
                r_idx <= req_rst_idx;
            end
        end
    end

    // Capture the reset bit selected by a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (accept && cg_op_e'(req_op) == OP_RST_READ)
            status_q <= rst_bit;
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/periph_clk_rst_ctl.sv
// Top: peripheral clock enable unit with reset sequencing.
// Wait intervals are PRE_US and POST_US microseconds at CYC_PER_US cycles
// each. Assumes: NUM_CLK is a power of two so every index is in range.
module periph_clk_rst_ctl #(
    parameter int                 NUM_CLK    = 32,
    parameter int                 CYC_PER_US = 100,
    parameter int                 PRE_US     = 100,
    parameter int                 POST_US    = 10000,
    parameter int                 INV_BIT    = 14,
    parameter logic [NUM_CLK-1:0] CRIT_MASK  = NUM_CLK'(32'h0000_0044),
    localparam int                IDX_W      = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [IDX_W-1:0]   req_clk_idx,
    input  logic [IDX_W-1:0]   req_rst_idx,
    input  logic               req_rst_vld,
    output logic               busy,
    output logic               done,
    output logic               rst_status,
    output logic [NUM_CLK-1:0] stop_reg,
    output logic [NUM_CLK-1:0] rst_reg,
    output logic [NUM_CLK-1:0] clk_en
);
    localparam int PRE_CYC  = PRE_US * CYC_PER_US;
    localparam int POST_CYC = POST_US * CYC_PER_US;
    localparam int MAX_CYC  = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_expired;
    logic [CW-1:0]    tmr_val;
    logic             clk_wr, clk_run, rst_wr, rst_val;
    logic [IDX_W-1:0] clk_widx, rst_widx;
    logic             cur_en, rst_bit;

    assign cur_en  = clk_en[req_clk_idx];
    assign rst_bit = rst_reg[req_rst_idx];

    cg_seq #(.IW(IDX_W), .CW(CW), .PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op),
        .req_clk_idx(req_clk_idx), .req_rst_idx(req_rst_idx),
        .req_rst_vld(req_rst_vld),
        .cur_en(cur_en), .rst_bit(rst_bit), .tmr_expired(tmr_expired),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .clk_wr(clk_wr), .clk_run(clk_run), .clk_widx(clk_widx),
        .rst_wr(rst_wr), .rst_val(rst_val), .rst_widx(rst_widx),
        .busy(busy), .done(done), .status_q(rst_status)
    );

    cg_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    cg_regs #(.NUM_CLK(NUM_CLK), .INV_BIT(INV_BIT), .CRIT_MASK(CRIT_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .clk_wr(clk_wr), .clk_run(clk_run), .clk_widx(clk_widx),
        .rst_wr(rst_wr), .rst_val(rst_val), .rst_widx(rst_widx),
        .stop_q(stop_reg), .rst_q(rst_reg), .clk_en(clk_en)
    );
endmodule

// File: rtl/cg_rs_chk.sv
// Protocol checker for periph_clk_rst_ctl, attached by bind below.
module cg_rs_chk
    import cgrs_pkg::*;
#(
    parameter int                 NUM_CLK   = 32,
    parameter logic [NUM_CLK-1:0] CRIT_MASK = '0,
    localparam int                IW        = $clog2(NUM_CLK)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         req_op,
    input logic [IW-1:0]      req_clk_idx,
    input logic               busy,
    input logic               done,
    input logic [NUM_CLK-1:0] rst_reg,
    input logic [NUM_CLK-1:0] clk_en
);
    // R10: done lasts exactly one cycle
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an accepted request raises busy
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R7: critical clocks always run
    a_r7_crit_running: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_en & CRIT_MASK) == CRIT_MASK));

    // R6: a disable request leaves the reset vector alone
    a_r6_off_keeps_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_CLK_OFF) |=> (rst_reg == $past(rst_reg)));

    // R8: reset vector never changes more than one bit per cycle
    a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rst_reg ^ $past(rst_reg)) <= 1));

    // R5: enabling a running clock completes next cycle without reset change
    a_r5_already_on: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_CLK_ON && clk_en[req_clk_idx])
        |=> (done && rst_reg == $past(rst_reg)));
endmodule

bind periph_clk_rst_ctl cg_rs_chk #(.NUM_CLK(NUM_CLK), .CRIT_MASK(CRIT_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_clk_idx(req_clk_idx), .busy(busy), .done(done),
    .rst_reg(rst_reg), .clk_en(clk_en)
);

// File: tb/sim_periph_clk_rst_ctl.sv
`timescale 1ns/1ps
module sim_periph_clk_rst_ctl;
    localparam int N     = 32;
    localparam int NPRE  = 6;   // 3 us * 2 cycles
    localparam int NPOST = 10;  // 5 us * 2 cycles
    localparam logic [31:0] CRIT = 32'h0000_0044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [4:0]  req_clk_idx = '0;
    logic [4:0]  req_rst_idx = '0;
    logic        req_rst_vld = 1'b0;
    logic        busy, done, rst_status;
    logic [31:0] stop_reg, rst_reg, clk_en;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    periph_clk_rst_ctl #(.NUM_CLK(N), .CYC_PER_US(2), .PRE_US(3), .POST_US(5)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_clk_idx(req_clk_idx), .req_rst_idx(req_rst_idx),
        .req_rst_vld(req_rst_vld), .busy(busy), .done(done),
        .rst_status(rst_status), .stop_reg(stop_reg), .rst_reg(rst_reg),
        .clk_en(clk_en)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_stop, m_rst;
    bit          m_stat;
    int          m_ph, m_wait, m_c, m_r;

    function automatic bit m_en(logic [31:0] s, int i);
        return (i == 14) ? s[i] : !s[i];
    endfunction

    function automatic logic [31:0] m_en_vec(logic [31:0] s);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m_en(s, i);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop = 32'hFFFF_BFBB;
            m_rst  = '1;
            m_stat = 0;
            m_ph   = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_c = req_clk_idx;
                    m_r = req_rst_idx;
                    m_ph = 3;
                    case (req_op)
                        3'd0: if (!m_en(m_stop, m_c)) begin
                            if (req_rst_vld) begin
                                m_rst[m_r] = 1'b1;
                                m_wait = NPRE;
                                m_ph = 1;
                            end else m_stop[m_c] = (m_c == 14);
                        end
                        3'd1: if (!CRIT[m_c]) m_stop[m_c] = (m_c != 14);
                        3'd2: m_rst[m_r] = 1'b1;
                        3'd3: m_rst[m_r] = 1'b0;
                        3'd4: m_stat = m_rst[m_r];
                        default: ;
                    endcase
                end
                1: begin
                    m_wait--;
                    if (m_wait == 0) begin
                        m_stop[m_c] = (m_c == 14);
                        m_wait = NPOST;
                        m_ph = 2;
                    end
                end
                2: begin
                    m_wait--;
                    if (m_wait == 0) begin
                        m_rst[m_r] = 1'b0;
                        m_ph = 3;
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 stop_reg model", stop_reg, m_stop);
            chk("R8 rst_reg model", rst_reg, m_rst);
            chk("R11 clk_en model", clk_en, m_en_vec(m_stop));
            chk("R10 busy model", {31'd0, busy}, {31'd0, m_ph != 0});
            chk("R10 done model", {31'd0, done}, {31'd0, m_ph == 3});
            chk("R9 rst_status model", {31'd0, rst_status}, {31'd0, m_stat});
        end
    end

    // ---------------- stimulus helpers ----------------
    // Drive one request for one cycle; returns at the negedge after the accepting edge.
    task automatic issue(logic [2:0] op, int c, int r, bit v);
        while (busy) @(negedge clk);
        req_op = op; req_clk_idx = 5'(c); req_rst_idx = 5'(r); req_rst_vld = v;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Count negedges from the accepting edge until done; first call sees n=1.
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    int nd;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rst_reg after reset", rst_reg, 32'hFFFF_FFFF);
        chk("R1 clk_en after reset", clk_en, CRIT);
        chk("R2 stop_reg after reset", stop_reg, 32'hFFFF_BFBB);

        // Release reset 6 so the sequence's own assertion is visible.
        issue(3'd3, 0, 6, 0); wait_done(nd);
        chk("R8 clear only bit 6", rst_reg, 32'hFFFF_FFBF);
        @(negedge clk);

        // R3 timed enable: clock 3 with reset 6
        issue(3'd0, 3, 6, 1);
        nd = 1;
        chk("R3 reset asserted at accept", {31'd0, rst_reg[6]}, 32'd1);
        while (!done && nd < 200) begin
            if (nd == NPRE)         chk("R3 still gated before pre wait ends", {31'd0, clk_en[3]}, 32'd0);
            if (nd == NPRE + 1)     chk("R3 ungated after pre wait", {31'd0, clk_en[3]}, 32'd1);
            if (nd == NPRE + NPOST) chk("R3 reset held through post wait", {31'd0, rst_reg[6]}, 32'd1);
            @(negedge clk);
            nd++;
        end
        chk("R3 done cycle", nd, NPRE + NPOST + 1);
        chk("R3 reset released", {31'd0, rst_reg[6]}, 32'd0);
        @(negedge clk);

        // R4 and R2: enable inverted-polarity clock 14 without reset
        issue(3'd0, 14, 9, 0); wait_done(nd);
        chk("R4 done next cycle", nd, 1);
        chk("R2 inverted bit set when running", {31'd0, stop_reg[14]}, 32'd1);
        chk("R4 rst_reg untouched", rst_reg, 32'hFFFF_FFBF);
        @(negedge clk);

        // R5 already running: reset 6 must stay released
        issue(3'd0, 3, 6, 1); wait_done(nd);
        chk("R5 done next cycle", nd, 1);
        chk("R5 reset bit untouched", {31'd0, rst_reg[6]}, 32'd0);
        @(negedge clk);

        // R6 disable clock 3
        issue(3'd1, 3, 6, 0); wait_done(nd);
        chk("R6 clock stopped", {31'd0, clk_en[3]}, 32'd0);
        chk("R6 stop bit set", {31'd0, stop_reg[3]}, 32'd1);
        chk("R6 rst_reg untouched", rst_reg, 32'hFFFF_FFBF);
        @(negedge clk);

        // R7 disable critical clock 2
        issue(3'd1, 2, 0, 0); wait_done(nd);
        chk("R7 critical clock still runs", {31'd0, clk_en[2]}, 32'd1);
        @(negedge clk);

        // R8 clear bit 1, then set bit 6
        issue(3'd3, 0, 1, 0); wait_done(nd);
        chk("R8 clear bit 1", rst_reg, 32'hFFFF_FFBD);
        @(negedge clk);
        issue(3'd2, 0, 6, 0); wait_done(nd);
        chk("R8 set bit 6", rst_reg, 32'hFFFF_FFFD);
        @(negedge clk);

        // R9 status reads
        issue(3'd4, 0, 1, 0); wait_done(nd);
        chk("R9 read cleared bit", {31'd0, rst_status}, 32'd0);
        @(negedge clk);
        issue(3'd4, 0, 6, 0); wait_done(nd);
        chk("R9 read set bit", {31'd0, rst_status}, 32'd1);
        @(negedge clk);

        // R10 request while busy is dropped: enable 5 with reset 7, inject disable of 14
        issue(3'd0, 5, 7, 1);
        repeat (2) @(negedge clk);
        chk("R10 busy during sequence", {31'd0, busy}, 32'd1);
        req_op = 3'd1; req_clk_idx = 5'd14; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 dropped request had no effect", {31'd0, clk_en[14]}, 32'd1);
        chk("R11 clk_en after sequence", {31'd0, clk_en[5]}, 32'd1);
        @(negedge clk);
        chk("R10 busy low after done", {31'd0, busy}, 32'd0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end
endmodule